// File: doc/BRIEF.md
# Conversion Wait and Strong Pull-Up Controller

This block takes over a single-conductor temperature sensor bus once a conversion command or a scratchpad-to-EEPROM copy command has gone out. It decides how the master learns that the sensor has finished. The command type, the power mode and a two-bit resolution code are captured when `start` is accepted.

With a dedicated supply, the block keeps asking a separate slot engine for read slots. It finishes when a slot returns a one. If no one arrives within the worst-case time plus a margin, it raises a sticky timeout. When the sensor draws its energy from the data line, the block never polls. It drives an active pull-up enable for a fixed worst-case hold time and drops the enable in the same cycle that it returns to idle, before any further bus traffic. The conversion hold doubles with each step of resolution. The copy hold is a separate parameter.

All times are counted in clock cycles. `BASE_TICKS` is the 9-bit conversion time, `COPY_TICKS` is the EEPROM write interval and `MARGIN_TICKS` is the extra polling allowance.

Top module: `convwait_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, `spu_en`, `slot_req`, `busy` and `timeout` are all 0.
- R2: A `start` sampled while `busy` is 0 makes `busy` 1 from the next cycle and captures `cmd_copy`, `parasite` and `res_code`. A `start` sampled while `busy` is 1 is ignored and does not change the running operation.
- R3: For a conversion (`cmd_copy`=0) with `parasite`=1, `spu_en` is 1 for exactly BASE_TICKS·2^`res_code` cycles, starting the cycle after `start` is sampled. Code 00 selects 9 bits, 01 selects 10 bits, 10 selects 11 bits and 11 selects 12 bits.
- R4: For a copy (`cmd_copy`=1) with `parasite`=1, `spu_en` is 1 for exactly COPY_TICKS cycles, whatever `res_code` is.
- R5: `slot_req` is never 1 during a parasite-mode operation. `busy` and `spu_en` fall in the same cycle, so the pull-up is off once the block is idle.
- R6: With `parasite`=0, `slot_req` stays 1 from the cycle after `start` is sampled until a `slot_done` pulse carries `slot_bit`=1. A `slot_done` pulse with `slot_bit`=0 leaves polling running.
- R7: The cycle after a `slot_done` pulse with `slot_bit`=1 during polling, `busy` and `slot_req` are 0 and `timeout` is 0.
- R8: If polling receives no one within W cycles, `busy` falls after exactly W cycles and `timeout` becomes 1. W is the hold time of R3 or R4 plus MARGIN_TICKS. `timeout` then stays 1 until the next accepted `start`, which clears it.
- R9: `spu_en` and `slot_req` are never 1 in the same cycle.
- R10: A one that arrives in the last cycle of the polling window counts as success, and `timeout` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the wait after a command has been sent |
| cmd_copy | input | 1 | 0: temperature conversion, 1: EEPROM copy |
| parasite | input | 1 | 1: sensor powered from the data line |
| res_code | input | 2 | Resolution code, 00 for 9 bits up to 11 for 12 bits |
| slot_done | input | 1 | One-cycle pulse: a requested read slot has finished |
| slot_bit | input | 1 | Bit read in the finished slot, valid with `slot_done` |
| slot_req | output | 1 | Request for another read slot |
| spu_en | output | 1 | Strong pull-up enable |
| busy | output | 1 | An operation is in progress |
| timeout | output | 1 | Polling expired without a one (sticky) |

## Verification
Parasite holds run at all four resolution codes and for both command types. This separates the doubling conversion hold from the fixed copy hold. External-mode runs change the number of zero results and the gap between slots, which shows that only a one ends polling and that the end comes one cycle after it. A responder that never returns a one exposes the window length and the sticky timeout. A one placed in the final window cycle separates success from expiry. A second `start` issued in the middle of a hold shows whether it leaks into the captured mode or resolution.

// File: rtl/convwait_pkg.sv
package convwait_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_POLL = 2'd2
  } cw_state_e;

  // Worst-case busy time of the sensor for one command, in clock cycles.
  function automatic logic [31:0] hold_ticks(input logic is_copy,
                                             input logic [1:0] res,
                                             input logic [31:0] base,
                                             input logic [31:0] copy);
    return is_copy ? copy : (base << res);
  endfunction

endpackage

// File: rtl/convwait_window.sv
module convwait_window import convwait_pkg::*; #(
  parameter int unsigned BASE_TICKS   = 16,
  parameter int unsigned COPY_TICKS   = 24,
  parameter int unsigned MARGIN_TICKS = 8,
  parameter int unsigned CW           = 8
) (
  input  logic          is_copy,
  input  logic          parasite,
  input  logic [1:0]    res,
  output logic [CW-1:0] limit
);
  logic [31:0] hold_w;

  always_comb begin
    hold_w = hold_ticks(is_copy, res, 32'(BASE_TICKS), 32'(COPY_TICKS));
    if (parasite) limit = CW'(hold_w);
    else          limit = CW'(hold_w + 32'(MARGIN_TICKS));
  end
endmodule

// File: rtl/convwait_timer.sv
module convwait_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [CW-1:0] limit,
  output logic          last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (en)    cnt <= cnt + 1'b1;
  end

  assign last = (cnt == limit - 1'b1);
endmodule

// File: rtl/convwait_ctrl.sv
module convwait_ctrl import convwait_pkg::*; #(
  parameter int unsigned BASE_TICKS   = 11718750,
  parameter int unsigned COPY_TICKS   = 1250000,
  parameter int unsigned MARGIN_TICKS = 1250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       cmd_copy,
  input  logic       parasite,
  input  logic [1:0] res_code,
  input  logic       slot_done,
  input  logic       slot_bit,
  output logic       slot_req,
  output logic       spu_en,
  output logic       busy,
  output logic       timeout
);
  localparam longint unsigned CONV_MAX = longint'(BASE_TICKS) * 8;
  localparam longint unsigned HOLD_MAX = (CONV_MAX > COPY_TICKS) ? CONV_MAX : COPY_TICKS;
  localparam int unsigned     CW       = $clog2(HOLD_MAX + MARGIN_TICKS + 1);

  cw_state_e     state;
  logic          copy_q, par_q, to_q;
  logic [1:0]    res_q;
  logic [CW-1:0] limit;
  logic          win_last;

  // Named events for the checker.
  logic ev_accept, ev_success, ev_expire, ev_hold_end;
  assign ev_accept   = start && (state == ST_IDLE);
  assign ev_success  = (state == ST_POLL) && slot_done && slot_bit;
  assign ev_expire   = (state == ST_POLL) && win_last && !ev_success;
  assign ev_hold_end = (state == ST_HOLD) && win_last;

  convwait_window #(
    .BASE_TICKS(BASE_TICKS), .COPY_TICKS(COPY_TICKS),
    .MARGIN_TICKS(MARGIN_TICKS), .CW(CW)
  ) u_window (
    .is_copy(copy_q), .parasite(par_q), .res(res_q), .limit(limit)
  );

  convwait_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(ev_accept),
    .en(state != ST_IDLE), .limit(limit), .last(win_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      copy_q <= 1'b0;
      par_q  <= 1'b0;
      res_q  <= 2'b00;
      to_q   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (ev_accept) begin
          copy_q <= cmd_copy;
          par_q  <= parasite;
          res_q  <= res_code;
          to_q   <= 1'b0;
          state  <= parasite ? ST_HOLD : ST_POLL;
        end
        ST_HOLD: if (ev_hold_end) state <= ST_IDLE;
        ST_POLL: begin
          if (ev_success) state <= ST_IDLE;
          else if (ev_expire) begin
            state <= ST_IDLE;
            to_q  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign spu_en   = (state == ST_HOLD);
  assign slot_req = (state == ST_POLL);
  assign busy     = (state != ST_IDLE);
  assign timeout  = to_q;
endmodule

// File: rtl/convwait_ctrl_chk.sv
module convwait_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       slot_req,
  input logic       spu_en,
  input logic       busy,
  input logic       timeout,
  input logic       par_q,
  input logic       copy_q,
  input logic [1:0] res_q,
  input logic       ev_success,
  input logic       ev_expire
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!spu_en && !slot_req));

  p_ignore_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(par_q) && $stable(copy_q) && $stable(res_q)));

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !timeout));

  p_spu_parasite_r3: assert property (@(posedge clk) disable iff (!rst_n)
    spu_en |-> par_q);

  p_no_poll_parasite_r5: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req |-> !par_q);

  p_success_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_success |=> (!busy && !timeout && !slot_req));

  p_expire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_expire |=> (timeout && !busy));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !start) |=> timeout);

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(spu_en && slot_req));
endmodule

bind convwait_ctrl convwait_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .slot_req(slot_req),
  .spu_en(spu_en), .busy(busy), .timeout(timeout), .par_q(par_q),
  .copy_q(copy_q), .res_q(res_q), .ev_success(ev_success),
  .ev_expire(ev_expire)
);

// File: tb/convwait_ctrl_bench.sv
module convwait_ctrl_bench;
  localparam int BASE = 16, COPY = 24, MARGIN = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, cmd_copy = 1'b0, parasite = 1'b0;
  logic [1:0] res_code = 2'b00;
  logic slot_done = 1'b0, slot_bit = 1'b0;
  logic slot_req, spu_en, busy, timeout;

  convwait_ctrl #(.BASE_TICKS(BASE), .COPY_TICKS(COPY), .MARGIN_TICKS(MARGIN)) u_convwait_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_copy(cmd_copy),
    .parasite(parasite), .res_code(res_code), .slot_done(slot_done),
    .slot_bit(slot_bit), .slot_req(slot_req), .spu_en(spu_en),
    .busy(busy), .timeout(timeout)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  typedef struct {
    int busy_len;
    int spu_len;
    int req_len;
    int to;
  } exp_t;
  exp_t sbq[$];

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int hold_of(bit cp, logic [1:0] r);
    int h;
    if (cp) h = COPY;
    else begin
      h = BASE;
      for (int i = 0; i < int'(r); i++) h = h * 2;
    end
    return h;
  endfunction

  // Monitor: measures each operation and compares it with the scoreboard.
  int bl = 0, sl = 0, rl = 0;
  bit pb = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && spu_en && slot_req) check(1'b0, "R9", "pull-up and slot request together", 1, 0);
      if (busy) begin
        bl++;
        if (spu_en) sl++;
        if (slot_req) rl++;
      end else if (pb) begin
        if (sbq.size() == 0) check(1'b0, "R2", "operation without expectation", 1, 0);
        else begin
          exp_t e;
          e = sbq.pop_front();
          check(bl == e.busy_len, "R2", "busy length", bl, e.busy_len);
          check(sl == e.spu_len, "R3 R4", "pull-up length", sl, e.spu_len);
          check(rl == e.req_len, "R5 R6", "slot request length", rl, e.req_len);
          check(int'(timeout) == e.to, "R7 R8", "timeout flag", int'(timeout), e.to);
        end
        bl = 0; sl = 0; rl = 0;
      end
      pb = busy;
    end
  end

  task automatic start_cmd(bit cp, bit par, logic [1:0] r);
    @(negedge clk);
    cmd_copy = cp; parasite = par; res_code = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
    check(timeout == 1'b0, "R8", "timeout cleared by start", int'(timeout), 0);
  endtask

  task automatic run_par(bit cp, logic [1:0] r);
    int h = hold_of(cp, r);
    sbq.push_back('{h, h, 0, 0});
    start_cmd(cp, 1'b1, r);
    repeat (h + 2) @(negedge clk);
    check(spu_en == 1'b0, "R5", "pull-up off when idle", int'(spu_en), 0);
  endtask

  task automatic run_ext(bit cp, logic [1:0] r, int nzero, int d);
    int j1 = d + nzero * (d + 1);
    sbq.push_back('{j1 + 1, 0, j1 + 1, 0});
    start_cmd(cp, 1'b0, r);
    for (int k = 0; k <= nzero; k++) begin
      repeat (d) @(negedge clk);
      slot_done = 1'b1;
      slot_bit = (k == nzero);
      @(negedge clk);
      slot_done = 1'b0;
      slot_bit = 1'b0;
    end
    check(busy == 1'b0 && slot_req == 1'b0, "R7", "idle after one", int'(busy), 0);
    check(timeout == 1'b0, "R7", "no timeout on success", int'(timeout), 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_timeout(bit cp, logic [1:0] r);
    int w = hold_of(cp, r) + MARGIN;
    sbq.push_back('{w, 0, w, 1});
    start_cmd(cp, 1'b0, r);
    slot_bit = 1'b0;
    while (busy) begin
      slot_done = ~slot_done;
      @(negedge clk);
    end
    slot_done = 1'b0;
    repeat (6) @(negedge clk);
    check(timeout == 1'b1, "R8", "timeout stays set", int'(timeout), 1);
  endtask

  task automatic run_last(logic [1:0] r);
    int w = hold_of(1'b0, r) + MARGIN;
    sbq.push_back('{w, 0, w, 0});
    start_cmd(1'b0, 1'b0, r);
    repeat (w - 1) @(negedge clk);
    slot_done = 1'b1; slot_bit = 1'b1;
    @(negedge clk);
    slot_done = 1'b0; slot_bit = 1'b0;
    check(timeout == 1'b0, "R10", "one in last window cycle wins", int'(timeout), 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_ignored();
    int h = hold_of(1'b0, 2'b01);
    sbq.push_back('{h, h, 0, 0});
    start_cmd(1'b0, 1'b1, 2'b01);
    repeat (5) @(negedge clk);
    cmd_copy = 1'b1; parasite = 1'b0; res_code = 2'b11; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(slot_req == 1'b0 && spu_en == 1'b1, "R2", "start while busy ignored", int'(slot_req), 0);
    repeat (h + 2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(spu_en == 1'b0 && slot_req == 1'b0, "R1", "outputs in reset", int'(spu_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(spu_en == 1'b0, "R1", "spu_en after reset", int'(spu_en), 0);
    check(slot_req == 1'b0, "R1", "slot_req after reset", int'(slot_req), 0);
    check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    check(timeout == 1'b0, "R1", "timeout after reset", int'(timeout), 0);

    for (int r = 0; r < 4; r++) run_par(1'b0, 2'(r));   // R3
    run_par(1'b1, 2'b10);                                // R4
    run_par(1'b1, 2'b00);                                // R4
    run_ext(1'b0, 2'b00, 0, 2);                          // R6
    run_ext(1'b0, 2'b11, 3, 4);                          // R6
    run_ext(1'b1, 2'b01, 2, 1);                          // R6 copy
    run_ext(1'b0, 2'b10, 5, 0);                          // R6 back-to-back slots
    run_timeout(1'b0, 2'b00);                            // R8
    run_ext(1'b0, 2'b01, 1, 3);                          // R8 clear on next start
    run_timeout(1'b1, 2'b11);                            // R8 copy window
    run_last(2'b00);                                     // R10
    run_ignored();                                       // R2
    repeat (4) @(negedge clk);
    check(sbq.size() == 0, "R2", "pending expectations", sbq.size(), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule